// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Queue

This block watches the inbound write stream of a host bridge. A write whose 64-bit address falls inside a programmable window while capture is on is treated as a message-signalled interrupt. The block stores the message's data word and its full address as one entry of a small queue. Typically each vector `v` writes the value `v` to `base + 4*v`, so the queue records which vectors fired and in what order.

Software uses a 32-bit register port with a one-cycle read latency. It programs the window base (two halves), the window size and the capture switch. It polls a status word and drains the queue head through three read-only words: data, address low and address high. An entry leaves the queue only when all three of its words have been read, in any order. A single interrupt line stays high while messages are waiting and capture is enabled.

Top module: `msi_capture_top`

## Requirements
- R1: After synchronous reset, every register reads 0, the status word is 0 and `irq` is low.
- R2: Register offsets: base low 0x04, base high 0x08, window size 0x0C, capture switch 0x14 (bit 0 only), status 0x18, head data 0x20, head address low 0x24, head address high 0x28. The first four read back what was written. Read data appears on `csr_rdata` one clock after the read is sampled.
- R3: A message is captured only while capture switch bit 0 is 1. A message sent while the switch is 0 leaves the status at 0.
- R4: A message is captured only if its address A satisfies base <= A < base + size, using 64-bit addresses. A message at base + size or below base leaves the queue unchanged.
- R5: Status bit 0 reads 1 while at least one entry is queued.
- R6: Offsets 0x20, 0x24 and 0x28 return the head entry's data, address bits 31:0 and address bits 63:32. With an empty queue they return 0.
- R7: The head entry is removed only after its data, address-low and address-high words have each been read at least once, in any order. Repeating one of these reads does not remove it.
- R8: Entries leave the queue in the order their messages arrived.
- R9: The queue holds DEPTH (default 16) entries. A message that arrives while the queue is full is dropped and sets status bit 1 (sticky overflow). Writing the status word with bit 1 set clears the overflow flag.
- R10: `irq` is registered. In each cycle it equals the value of (queue non-empty AND capture switch bit 0) from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Inbound write strobe |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | DW | Inbound write data |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after the read |
| irq | output | 1 | Pending-message interrupt |

## Verification
The bound checker watches several properties on every cycle. The occupancy never exceeds the depth. Nothing is removed from an empty queue. A capture never follows a disabled cycle. An arrival at a full queue always sets the overflow flag. `irq` tracks the pending-and-enabled condition one cycle later. Other behaviour is visible only in the directed scenarios. These cover the exact window bounds at both ends and the arrival order of the drained entries. They also show that repeated or partial reads keep the head in place, and that the overflow flag clears on request.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int ADDR_W = 64;
  localparam int REG_W  = 32;

  localparam logic [7:0] OFS_BASE_LO = 8'h04;
  localparam logic [7:0] OFS_BASE_HI = 8'h08;
  localparam logic [7:0] OFS_SIZE    = 8'h0C;
  localparam logic [7:0] OFS_ENABLE  = 8'h14;
  localparam logic [7:0] OFS_STATUS  = 8'h18;
  localparam logic [7:0] OFS_DATA    = 8'h20;
  localparam logic [7:0] OFS_ADDR_LO = 8'h24;
  localparam logic [7:0] OFS_ADDR_HI = 8'h28;

  // which of the three head words have been read
  typedef enum logic [1:0] {
    WORD_DATA = 2'd0,
    WORD_ALO  = 2'd1,
    WORD_AHI  = 2'd2
  } head_word_e;
endpackage

// File: rtl/msi_cap_window.sv
module msi_cap_window
  import msi_cap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DW-1:0]     msg_data,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [REG_W-1:0]  win_size,
  input  logic              win_en,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DW-1:0]     cap_data
);
  // one extra bit so a window touching the top of the space does not wrap
  logic [ADDR_W:0] win_end;
  logic            hit;

  always_comb begin
    win_end = {1'b0, win_base} + {{(ADDR_W+1-REG_W){1'b0}}, win_size};
    hit = msg_valid && win_en &&
          (msg_addr >= win_base) &&
          ({1'b0, msg_addr} < win_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      cap_valid <= hit;
      if (hit) begin
        cap_addr <= msg_addr;
        cap_data <= msg_data;
      end
    end
  end
endmodule

// File: rtl/msi_cap_fifo.sv
module msi_cap_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 96
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  always_comb begin
    empty   = (count == '0);
    full    = (count == CNT_MAX);
    do_pop  = pop && !empty;
    do_push = push && (!full || do_pop);
    head    = mem[rd_ptr];
  end

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/msi_cap_popseq.sv
module msi_cap_popseq
  import msi_cap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic head_valid,
  input  logic rd_hit,
  input  logic [1:0] rd_word,
  output logic pop
);
  localparam int NWORDS = 3;

  logic [NWORDS-1:0] seen_q, seen_nxt, hit_vec;

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_hit
      assign hit_vec[w] = head_valid && rd_hit && (rd_word == 2'(w));
    end
  endgenerate

  always_comb begin
    seen_nxt = seen_q | hit_vec;
    pop      = &seen_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= pop ? '0 : seen_nxt;
  end
endmodule

// File: rtl/msi_capture_top.sv
module msi_capture_top
  import msi_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [63:0]       msg_addr,
  input  logic [DW-1:0]     msg_data,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [7:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq
);
  localparam int ENTRY_W = ADDR_W + DW;
  localparam int CNT_W   = $clog2(DEPTH) + 1;

  logic [ADDR_W-1:0]  base_q;
  logic [REG_W-1:0]   size_q;
  logic               en_q;
  logic               ovf_q;

  logic               cap_valid;
  logic [ADDR_W-1:0]  cap_addr;
  logic [DW-1:0]      cap_data;

  logic [ENTRY_W-1:0] head;
  logic               empty, full, pop, push;
  logic [CNT_W-1:0]   count;
  logic [ADDR_W-1:0]  head_addr;
  logic [DW-1:0]      head_data;

  logic               rd_head;
  logic [1:0]         rd_word;
  logic               drop;

  msi_cap_window #(.DW(DW)) win_i (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .win_base  (base_q),
    .win_size  (size_q),
    .win_en    (en_q),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data)
  );

  assign push = cap_valid;

  msi_cap_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) fifo_i (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata ({cap_addr, cap_data}),
    .pop   (pop),
    .head  (head),
    .empty (empty),
    .full  (full),
    .count (count)
  );

  assign head_addr = head[ENTRY_W-1:DW];
  assign head_data = head[DW-1:0];

  always_comb begin
    rd_head = 1'b0;
    rd_word = WORD_DATA;
    if (csr_rd) begin
      case (csr_addr)
        OFS_DATA:    begin rd_head = 1'b1; rd_word = WORD_DATA; end
        OFS_ADDR_LO: begin rd_head = 1'b1; rd_word = WORD_ALO;  end
        OFS_ADDR_HI: begin rd_head = 1'b1; rd_word = WORD_AHI;  end
        default:     rd_head = 1'b0;
      endcase
    end
  end

  msi_cap_popseq popseq_i (
    .clk        (clk),
    .rst        (rst),
    .head_valid (!empty),
    .rd_hit     (rd_head),
    .rd_word    (rd_word),
    .pop        (pop)
  );

  assign drop = cap_valid && full && !pop;

  // configuration and overflow registers
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (csr_wr) begin
        case (csr_addr)
          OFS_BASE_LO: base_q[31:0]  <= csr_wdata;
          OFS_BASE_HI: base_q[63:32] <= csr_wdata;
          OFS_SIZE:    size_q        <= csr_wdata;
          OFS_ENABLE:  en_q          <= csr_wdata[0];
          default:     ;
        endcase
      end
      if (drop)
        ovf_q <= 1'b1;
      else if (csr_wr && csr_addr == OFS_STATUS && csr_wdata[1])
        ovf_q <= 1'b0;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else if (csr_rd) begin
      case (csr_addr)
        OFS_BASE_LO: csr_rdata <= base_q[31:0];
        OFS_BASE_HI: csr_rdata <= base_q[63:32];
        OFS_SIZE:    csr_rdata <= size_q;
        OFS_ENABLE:  csr_rdata <= {31'd0, en_q};
        OFS_STATUS:  csr_rdata <= {30'd0, ovf_q, !empty};
        OFS_DATA:    csr_rdata <= empty ? '0 : 32'(head_data);
        OFS_ADDR_LO: csr_rdata <= empty ? '0 : head_addr[31:0];
        OFS_ADDR_HI: csr_rdata <= empty ? '0 : head_addr[63:32];
        default:     csr_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= !empty && en_q;
  end
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_valid,
  input logic             en_q,
  input logic             cap_valid,
  input logic             push,
  input logic             pop,
  input logic             full,
  input logic             ovf_q,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !pop);

  a_r3_disabled_no_capture: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !en_q) |=> !cap_valid);

  a_r9_drop_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && full && !pop) |=> (ovf_q && count == CNT_W'(DEPTH)));

  a_r8_count_stable: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(count));

  a_r10_irq_on: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && en_q) |=> irq);

  a_r10_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(count != '0 && en_q) |=> !irq);
endmodule

bind msi_capture_top msi_capture_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .en_q      (en_q),
  .cap_valid (cap_valid),
  .push      (push),
  .pop       (pop),
  .full      (full),
  .ovf_q     (ovf_q),
  .count     (count),
  .irq       (irq)
);

// File: tb/msi_capture_tb.sv
module msi_capture_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        csr_wr = 1'b0;
  logic        csr_rd = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_FEE0_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_capture_top #(.DEPTH(DEPTH), .DW(32)) dut_i (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    d = csr_rdata;
  endtask

  task automatic send_msg(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    csr_read(8'h04, v); chk("R1 base lo", v, 0);
    csr_read(8'h0C, v); chk("R1 size", v, 0);
    csr_read(8'h14, v); chk("R1 enable", v, 0);
    csr_read(8'h18, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    csr_write(8'h04, BASE[31:0]);
    csr_write(8'h08, BASE[63:32]);
    csr_write(8'h0C, 32'd4096);
    csr_read(8'h04, v); chk("R2 base lo", v, BASE[31:0]);
    csr_read(8'h08, v); chk("R2 base hi", v, BASE[63:32]);
    csr_read(8'h0C, v); chk("R2 size", v, 4096);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    send_msg(BASE + 8, 2);
    csr_read(8'h18, v); chk("R3 disabled status", v, 0);
    chk("R3 disabled irq", irq, 0);
    csr_write(8'h14, 32'h1);
    csr_read(8'h14, v); chk("R2 enable", v, 1);
  endtask

  task automatic drain_one(input logic [63:0] ea, input logic [31:0] ed, input string req);
    logic [31:0] v;
    csr_read(8'h20, v); chk({req, " data"}, v, ed);
    csr_read(8'h24, v); chk({req, " addr lo"}, v, ea[31:0]);
    csr_read(8'h28, v); chk({req, " addr hi"}, v, ea[63:32]);
  endtask

  task automatic t_window();
    logic [31:0] v;
    send_msg(BASE - 4, 7);
    csr_read(8'h18, v); chk("R4 below base", v, 0);
    send_msg(BASE + 4096, 7);
    csr_read(8'h18, v); chk("R4 at end", v, 0);
    send_msg(BASE + 4092, 32'd1023);
    csr_read(8'h18, v); chk("R4 last word captured", v, 1);
    drain_one(BASE + 4092, 1023, "R4");
    csr_read(8'h18, v); chk("R4 drained", v, 0);
  endtask

  task automatic t_popseq();
    logic [31:0] v;
    send_msg(BASE + 12, 3);
    csr_read(8'h18, v); chk("R5 pending", v, 1);
    chk("R10 irq pending", irq, 1);
    csr_read(8'h28, v); chk("R6 addr hi", v, BASE[63:32]);
    csr_read(8'h28, v); chk("R7 repeat hi", v, BASE[63:32]);
    csr_read(8'h20, v); chk("R6 data", v, 3);
    csr_read(8'h18, v); chk("R7 two of three kept", v, 1);
    csr_write(8'h14, 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 irq off when disabled", irq, 0);
    csr_write(8'h14, 32'h1);
    repeat (2) @(negedge clk);
    chk("R10 irq back", irq, 1);
    csr_read(8'h24, v); chk("R6 addr lo", v, BASE[31:0] + 12);
    csr_read(8'h18, v); chk("R7 popped after third", v, 0);
    repeat (2) @(negedge clk);
    chk("R10 irq idle", irq, 0);
    csr_read(8'h20, v); chk("R6 empty data", v, 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) send_msg(BASE + 64'(i) * 4, 32'(i));
    csr_read(8'h18, v); chk("R9 full no overflow", v, 1);
    send_msg(BASE + 64, 32'd99);
    csr_read(8'h18, v); chk("R9 overflow sticky", v, 3);
    for (int i = 0; i < DEPTH; i++) drain_one(BASE + 64'(i) * 4, 32'(i), "R8");
    csr_read(8'h18, v); chk("R9 dropped not stored", v, 2);
    csr_write(8'h18, 32'h2);
    csr_read(8'h18, v); chk("R9 overflow cleared", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_window();
    t_popseq();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule